// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block moves a group of registers between a register file and memory, one 32-bit word per clock handshake. It serves four instruction kinds: a stack push, a stack pop, a store-multiple to a base register and a load-multiple from a base register. One start strobe starts a transfer. The strobe carries the operation, an 8-bit register mask, an extra-register bit and the current base address.

Stack pushes are full-descending. Before the first store, the stack pointer is moved down by four bytes for each selected register. Pops, store-multiples and load-multiples all start at the base and count upward. Every form writes the new base back in one closing cycle that also carries a done pulse.

The extra bit adds the link register to a push and the program counter to a pop; the other two operations ignore it. A pop that loads the program counter has bit 0 of the loaded word cleared and raises a one-cycle flag.

Top module: `lsm_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done`, `base_wr_en`, `rf_wr_en` and `pc_loaded` are all low.
- R2: Push (`op`=2'b00) stores to addresses starting at `base_addr - 4*N` and rising by 4, where N is the number of selected registers. Bit n of `reg_mask` selects register n, and registers go in ascending order. When `extra` is set, register 14 goes last at the highest address. `mem_we` is 1 and `mem_wdata` equals the register-file data for `rf_rd_idx`.
- R3: Pop (`op`=2'b01) loads from `base_addr` upward by 4 in ascending register order. When `extra` is set, register 15 is loaded last. Each accepted beat writes `mem_rdata` to `rf_wr_idx` with `rf_wr_en` high in the same cycle.
- R4: Store-multiple (`op`=2'b10) and load-multiple (`op`=2'b11) start at `base_addr` and rise by 4. The `extra` input adds no beat for these operations.
- R5: One cycle after the last beat is accepted, `done` is high for exactly one cycle. In that same cycle `base_wr_en` is high and `base_wr_data` is `base_addr - 4*N` for push or `base_addr + 4*N` for the other operations.
- R6: With no register selected, no memory request is made. `done` rises in the cycle after the start is taken, and `base_wr_en` stays low.
- R7: While `mem_req` is high and `mem_ready` is low, the request, address, write flag and register index hold their values into the next cycle.
- R8: A program-counter load writes its data with bit 0 cleared. `pc_loaded` is high only in that write cycle.
- R9: A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| op | input | 2 | 00 push, 01 pop, 10 store-multiple, 11 load-multiple |
| reg_mask | input | 8 | Bit n selects register n |
| extra | input | 1 | Adds the link register (push) or the program counter (pop) |
| base_addr | input | 32 | Stack pointer or base register value |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory beat valid |
| mem_we | output | 1 | Beat is a store |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| base_wr_en | output | 1 | Write back the updated base |
| base_wr_data | output | 32 | Updated base value |
| done | output | 1 | Transfer complete pulse |
| pc_loaded | output | 1 | Program counter was loaded this cycle |

## Verification
The bench builds the block with its default parameters: an 8-bit mask, a 32-bit address and data path, and link and program-counter indices 14 and 15. With these values a full nine-beat list is reachable, and so is a push whose pre-decrement wraps below address zero. The memory model answers with no wait states in some runs and with two wait cycles per beat in others, so that the hold rule is exercised. The bench tracks the load data by address so that it can check the cleared program-counter bit.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   typedef enum logic [1:0] {
      OP_PUSH = 2'b00,
      OP_POP  = 2'b01,
      OP_STM  = 2'b10,
      OP_LDM  = 2'b11
   } lsm_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_XFER = 2'b01,
      ST_FIN  = 2'b10
   } lsm_state_e;

   function automatic logic op_is_store(input lsm_op_e o);
      return (o == OP_PUSH) || (o == OP_STM);
   endfunction

   function automatic logic op_is_stack(input lsm_op_e o);
      return (o == OP_PUSH) || (o == OP_POP);
   endfunction

endpackage

// File: rtl/lsm_pick.sv
module lsm_pick #(
   parameter int N     = 9,
   localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    vec,
   output logic [N-1:0]    first,
   output logic [IDXW-1:0] idx,
   output logic            any
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign seen[i+1] = seen[i] | vec[i];
      assign first[i]  = vec[i] & ~seen[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (first[i]) idx = IDXW'(i);
      end
   end

endmodule

// File: rtl/lsm_addr_calc.sv
module lsm_addr_calc
   import lsm_pkg::*;
#(
   parameter int N          = 9,
   parameter int ADDR_W     = 32,
   parameter int BEAT_SHIFT = 2,
   localparam int CNT_W     = $clog2(N + 1)
) (
   input  lsm_op_e           op,
   input  logic [N-1:0]      sel,
   input  logic [ADDR_W-1:0] base,
   output logic [CNT_W-1:0]  count,
   output logic [ADDR_W-1:0] first_addr,
   output logic [ADDR_W-1:0] new_base
);
   logic [CNT_W-1:0] part [N+1];
   logic [ADDR_W-1:0] span;

   assign part[0] = '0;

   for (genvar i = 0; i < N; i++) begin : g_cnt
      assign part[i+1] = part[i] + CNT_W'(sel[i]);
   end

   assign count = part[N];
   assign span  = ADDR_W'(count) << BEAT_SHIFT;

   always_comb begin
      if (op == OP_PUSH) begin
         first_addr = base - span;
         new_base   = base - span;
      end else begin
         first_addr = base;
         new_base   = base + span;
      end
   end

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
   import lsm_pkg::*;
#(
   parameter int LIST_W    = 8,
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int REG_IDX_W = 4,
   parameter int LR_IDX    = 14,
   parameter int PC_IDX    = 15
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [1:0]           op,
   input  logic [LIST_W-1:0]    reg_mask,
   input  logic                 extra,
   input  logic [ADDR_W-1:0]    base_addr,
   output logic                 busy,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic                 mem_ready,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic [REG_IDX_W-1:0] rf_rd_idx,
   input  logic [DATA_W-1:0]    rf_rd_data,
   output logic                 rf_wr_en,
   output logic [REG_IDX_W-1:0] rf_wr_idx,
   output logic [DATA_W-1:0]    rf_wr_data,
   output logic                 base_wr_en,
   output logic [ADDR_W-1:0]    base_wr_data,
   output logic                 done,
   output logic                 pc_loaded
);
   localparam int SET_W      = LIST_W + 1;
   localparam int PICK_W     = $clog2(SET_W);
   localparam int CNT_W      = $clog2(SET_W + 1);
   localparam int BEAT_BYTES = DATA_W / 8;
   localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);

   if (LIST_W < 1 || LIST_W >= (1 << REG_IDX_W)) begin : g_bad_list
      $error("lsm_seq: LIST_W must fit the register index");
   end
   if ((BEAT_BYTES << BEAT_SHIFT) != BEAT_BYTES * BEAT_BYTES && BEAT_BYTES != 1) begin : g_bad_data
      $error("lsm_seq: DATA_W must be a power-of-two number of bytes");
   end
   if (LR_IDX >= (1 << REG_IDX_W) || PC_IDX >= (1 << REG_IDX_W)) begin : g_bad_idx
      $error("lsm_seq: LR_IDX and PC_IDX must fit REG_IDX_W");
   end

   lsm_state_e        state_q;
   lsm_op_e           op_q;
   lsm_op_e           op_in;
   logic [SET_W-1:0]  pend_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] final_q;
   logic              wb_q;

   logic [SET_W-1:0]  req_set;
   logic [CNT_W-1:0]  req_cnt;
   logic [ADDR_W-1:0] req_first;
   logic [ADDR_W-1:0] req_final;

   logic [SET_W-1:0]  first_hot;
   logic [PICK_W-1:0] pick_idx;
   logic              pick_any;
   logic [SET_W-1:0]  pend_left;
   logic              beat_go;
   logic              cur_extra;
   logic [REG_IDX_W-1:0] cur_reg;

   assign op_in   = lsm_op_e'(op);
   assign req_set = {extra & op_is_stack(op_in), reg_mask};

   lsm_addr_calc #(
      .N          (SET_W),
      .ADDR_W     (ADDR_W),
      .BEAT_SHIFT (BEAT_SHIFT)
   ) u_calc (
      .op         (op_in),
      .sel        (req_set),
      .base       (base_addr),
      .count      (req_cnt),
      .first_addr (req_first),
      .new_base   (req_final)
   );

   lsm_pick #(
      .N     (SET_W)
   ) u_pick (
      .vec   (pend_q),
      .first (first_hot),
      .idx   (pick_idx),
      .any   (pick_any)
   );

   assign cur_extra = first_hot[LIST_W];
   assign pend_left = pend_q & ~first_hot;
   assign beat_go   = (state_q == ST_XFER) && mem_ready;

   always_comb begin
      if (cur_extra)
         cur_reg = (op_q == OP_POP) ? REG_IDX_W'(PC_IDX) : REG_IDX_W'(LR_IDX);
      else
         cur_reg = REG_IDX_W'(pick_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_PUSH;
         pend_q  <= '0;
         addr_q  <= '0;
         final_q <= '0;
         wb_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  op_q    <= op_in;
                  pend_q  <= req_set;
                  addr_q  <= req_first;
                  final_q <= req_final;
                  wb_q    <= (req_cnt != '0);
                  state_q <= (req_cnt != '0) ? ST_XFER : ST_FIN;
               end
            end
            ST_XFER: begin
               if (beat_go) begin
                  pend_q <= pend_left;
                  addr_q <= addr_q + ADDR_W'(BEAT_BYTES);
                  if (pend_left == '0) state_q <= ST_FIN;
               end
            end
            ST_FIN: begin
               wb_q    <= 1'b0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy         = (state_q != ST_IDLE);
   assign mem_req      = (state_q == ST_XFER) && pick_any;
   assign mem_we       = op_is_store(op_q);
   assign mem_addr     = addr_q;
   assign rf_rd_idx    = cur_reg;
   assign mem_wdata    = rf_rd_data;

   assign rf_wr_en     = beat_go && !op_is_store(op_q);
   assign rf_wr_idx    = cur_reg;
   assign pc_loaded    = rf_wr_en && cur_extra && (op_q == OP_POP);
   assign rf_wr_data   = pc_loaded ? {mem_rdata[DATA_W-1:1], 1'b0} : mem_rdata;

   assign done         = (state_q == ST_FIN);
   assign base_wr_en   = done && wb_q;
   assign base_wr_data = final_q;

endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int REG_IDX_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 busy,
   input logic                 mem_req,
   input logic                 mem_we,
   input logic [ADDR_W-1:0]    mem_addr,
   input logic                 mem_ready,
   input logic [REG_IDX_W-1:0] rf_rd_idx,
   input logic                 rf_wr_en,
   input logic [DATA_W-1:0]    rf_wr_data,
   input logic                 base_wr_en,
   input logic                 done,
   input logic                 pc_loaded
);
   localparam int STEP = DATA_W / 8;

   // R7: a stalled beat keeps its shape
   a_r7_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(rf_rd_idx));

   // R2/R3/R4: consecutive beats rise by one word
   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready |=> !mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(STEP)));

   // R5: done lasts a single cycle
   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: base write-back only in the done cycle
   a_r5_wb_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr_en |-> done);

   // R6: done never overlaps a memory beat
   a_r6_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);

   // R8: program-counter flag only with a write of an even value
   a_r8_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
      pc_loaded |-> rf_wr_en && !rf_wr_data[0]);

   // R9: requests only while busy
   a_r9_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

endmodule

bind lsm_seq lsm_seq_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .REG_IDX_W (REG_IDX_W)
) u_lsm_seq_chk (.*);

// File: tb/tb_lsm_seq.sv
module tb_lsm_seq;

   typedef struct packed {
      logic [31:0] addr;
      logic        we;
      logic [3:0]  idx;
      logic [31:0] data;
      logic        is_pc;
   } beat_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [7:0]  reg_mask = '0;
   logic        extra = 1'b0;
   logic [31:0] base_addr = '0;
   logic        busy, mem_req, mem_we, mem_ready, rf_wr_en, base_wr_en, done, pc_loaded;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data, base_wr_data;
   logic [3:0]  rf_rd_idx, rf_wr_idx;

   int total = 0;
   int fails = 0;
   int stall_mode = 0;
   int tick = 0;
   bit finished = 1'b0;
   beat_t exp_q[$];

   always #10 clk = ~clk;

   function automatic logic [31:0] rf_val(input logic [3:0] i);
      return 32'hBEEF_0000 | ({28'd0, i} * 32'h0101);
   endfunction

   function automatic logic [31:0] ld_val(input logic [31:0] a);
      return (a ^ 32'hC3C3_0000) | 32'h1;
   endfunction

   assign rf_rd_data = rf_val(rf_rd_idx);
   assign mem_rdata  = ld_val(mem_addr);

   lsm_seq dut (
      .clk, .rst_n, .start, .op, .reg_mask, .extra, .base_addr,
      .busy, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ready, .mem_rdata,
      .rf_rd_idx, .rf_rd_data, .rf_wr_en, .rf_wr_idx, .rf_wr_data,
      .base_wr_en, .base_wr_data, .done, .pc_loaded
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: drives ready, pops the scoreboard on each accepted beat
   initial begin
      mem_ready = 1'b0;
      forever begin
         @(negedge clk);
         tick++;
         mem_ready = (stall_mode == 0) ? 1'b1 : ((tick % 3) == 0);
         #1;
         if (mem_req && mem_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 unexpected beat", mem_addr, 32'h0);
            end else begin
               beat_t e;
               e = exp_q.pop_front();
               check(mem_addr == e.addr, "R2/R3/R4 addr", mem_addr, e.addr);
               check(mem_we == e.we, "R2/R3 write flag", {31'd0, mem_we}, {31'd0, e.we});
               if (e.we) begin
                  check(rf_rd_idx == e.idx, "R2 store index", {28'd0, rf_rd_idx}, {28'd0, e.idx});
                  check(mem_wdata == e.data, "R2 store data", mem_wdata, e.data);
               end else begin
                  check(rf_wr_en && rf_wr_idx == e.idx, "R3 load index",
                        {27'd0, rf_wr_en, rf_wr_idx}, {28'd1, e.idx});
                  check(rf_wr_data == e.data, "R8 load data", rf_wr_data, e.data);
                  check(pc_loaded == e.is_pc, "R8 pc flag", {31'd0, pc_loaded}, {31'd0, e.is_pc});
               end
            end
         end else if (rf_wr_en || pc_loaded) begin
            check(1'b0, "R8 stray write", {30'd0, rf_wr_en, pc_loaded}, 32'h0);
         end
      end
   end

   // driver: queue expected beats, launch, check the closing cycle
   task automatic run_op(input logic [1:0] o, input logic [7:0] m, input logic ex,
                         input logic [31:0] b, input bit inject);
      int n = 0;
      int k = 0;
      int w = 0;
      logic use_ex;
      logic [31:0] first, fin;
      use_ex = ex && (o == 2'b00 || o == 2'b01);
      for (int i = 0; i < 8; i++) n += m[i];
      n += use_ex;
      first = (o == 2'b00) ? b - 32'(4 * n) : b;
      fin   = (o == 2'b00) ? b - 32'(4 * n) : b + 32'(4 * n);
      for (int i = 0; i < 9; i++) begin
         if ((i < 8 && m[i]) || (i == 8 && use_ex)) begin
            beat_t e;
            e.addr  = first + 32'(4 * k);
            e.we    = (o == 2'b00 || o == 2'b10);
            e.idx   = (i < 8) ? 4'(i) : ((o == 2'b01) ? 4'd15 : 4'd14);
            e.is_pc = (i == 8) && (o == 2'b01);
            e.data  = e.we ? rf_val(e.idx)
                           : (e.is_pc ? (ld_val(e.addr) & ~32'h1) : ld_val(e.addr));
            exp_q.push_back(e);
            k++;
         end
      end
      @(negedge clk);
      start = 1'b1; op = o; reg_mask = m; extra = ex; base_addr = b;
      @(negedge clk);
      if (inject) begin
         // R9: a second start while busy must be dropped
         op = 2'b11; reg_mask = 8'hFF; extra = 1'b1; base_addr = 32'h0;
         @(negedge clk);
      end
      start = 1'b0;
      if (n == 0) check(done == 1'b1, "R6 done timing", {31'd0, done}, 32'h1);
      while (!done && w < 2000) begin
         @(negedge clk);
         w++;
      end
      check(done == 1'b1, "R5 done seen", {31'd0, done}, 32'h1);
      check(base_wr_en == (n != 0), "R5/R6 base write enable", {31'd0, base_wr_en}, {31'd0, n != 0});
      if (n != 0) check(base_wr_data == fin, "R5 base value", base_wr_data, fin);
      check(exp_q.size() == 0, "R2/R3/R9 beats left", 32'(exp_q.size()), 32'h0);
      exp_q.delete();
      @(negedge clk);
      check(!done && !busy, "R5 done single cycle", {30'd0, done, busy}, 32'h0);
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         check(1'b0, "watchdog", 32'h0, 32'h1);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check({busy, mem_req, done, base_wr_en, rf_wr_en, pc_loaded} == 6'b0, "R1 reset state",
            {26'd0, busy, mem_req, done, base_wr_en, rf_wr_en, pc_loaded}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      stall_mode = 0;
      run_op(2'b00, 8'b1010_0101, 1'b1, 32'h0000_1000, 1'b0); // R2 push with LR
      stall_mode = 1;
      run_op(2'b00, 8'b0000_0001, 1'b0, 32'h0000_1000, 1'b0); // R2/R7 single push, stalls
      run_op(2'b01, 8'b1001_0010, 1'b1, 32'h0000_2000, 1'b0); // R3/R8 pop with PC
      stall_mode = 0;
      run_op(2'b01, 8'hFF, 1'b0, 32'h0000_2100, 1'b0);        // R3 full pop
      run_op(2'b10, 8'h0F, 1'b1, 32'h0000_3000, 1'b0);        // R4 stm, extra ignored
      stall_mode = 1;
      run_op(2'b11, 8'h81, 1'b1, 32'h0000_4000, 1'b0);        // R4 ldm, extra ignored
      stall_mode = 0;
      run_op(2'b00, 8'h00, 1'b0, 32'h0000_5000, 1'b0);        // R6 empty push
      run_op(2'b11, 8'h00, 1'b1, 32'h0000_5000, 1'b0);        // R6/R4 empty ldm
      run_op(2'b01, 8'h00, 1'b1, 32'h0000_6000, 1'b0);        // R8 pop of PC alone
      stall_mode = 1;
      run_op(2'b00, 8'h3C, 1'b0, 32'h0000_7000, 1'b1);        // R9 start while busy
      stall_mode = 0;
      run_op(2'b00, 8'hFF, 1'b1, 32'h0000_0010, 1'b0);        // R2/R5 wrap below zero
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule